// File: doc/BRIEF.md
# Fractional Reference Clock Divider

This block derives a slower reference clock from its input clock. The output toggles at the end of each half-period. A half-period lasts an integer number of input cycles, and sometimes one cycle more. A 9-bit phase accumulator decides when the extra cycle is added, so the average output frequency is fin / (2 × (div + trim/512)). Equivalently, fin × 256 / (512 × div + trim).

Software writes two registers through a simple write port: a control word and a trim word. The integer divider and the trim value are held as staged copies. The running divider uses neither copy until a self-clearing switch bit is written. The switch moves both values into the running divider in the same cycle. A 4-bit source-select field is driven out to an external clock multiplexer, and it is frozen while the divider reports itself active. An integer divider of zero passes the input clock straight through.

Top module: `frac_ref_div`

## Requirements
- R1: After reset, `ctrlRd` and `trimRd` read zero and `refOut` is low.
- R2: Control word layout: source select in bits 3:0, active status in bit 8, switch request in bit 9, output enable in bit 12, on in bit 15 and the staged integer divider in bits 30:16. The active bit is read-only. Trim word layout: the staged trim in bits 31:23. All other bits read zero, and `srcSel` equals bits 3:0 of `ctrlRd`.
- R3: While running with a nonzero divider d and trim t, every half-period of `refOut` lasts d or d+1 input cycles. Any 512 consecutive half-periods after a switch total exactly 512·d + t cycles.
- R4: With trim zero, every half-period lasts exactly d input cycles.
- R5: When on and output enable are set and the running divider is zero, `refOut` follows the input clock: high while `clk` is high and low while it is low.
- R6: Writing the staged divider or trim alone leaves the output period unchanged. Writing a 1 to the switch bit sets it for exactly one cycle, then it clears itself. Both staged values take effect together when it clears.
- R7: The active bit rises one cycle after on is set and falls one cycle after on is cleared.
- R8: A write to the source-select field while active is set leaves `srcSel` unchanged. When active is clear, the write takes effect.
- R9: While output enable is clear, `refOut` stays low, the active bit stays set, and the divider keeps its cadence.
- R10: While the block is off, `refOut` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that is divided |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 selects the control word, 1 selects the trim word |
| regWdata | input | 32 | Write data |
| ctrlRd | output | 32 | Control word readback |
| trimRd | output | 32 | Trim word readback |
| srcSel | output | 4 | Source select towards the external clock mux |
| refOut | output | 1 | Divided reference clock |

## Verification
Most faults in the accumulator or the half-period counter show up at `refOut` within one half-period. Examples are a lost carry, a wrong reload length or an off-by-one end-of-count. Such a fault makes a half-period fall outside d or d+1, or shifts the total over 512 half-periods away from 512·d + t. Measuring that total catches even a single missing extra cycle. A staging fault appears as a period change before the switch bit clears. A switch bit that fails to clear is visible on `ctrlRd` two cycles after the write. A wrong active or select-freeze state shows on `ctrlRd` and `srcSel` on the cycle after the on bit changes.

// File: rtl/frac_ref_div_pkg.sv
package frac_ref_div_pkg;

  localparam int SEL_LSB  = 0;
  localparam int ACT_BIT  = 8;
  localparam int SW_BIT   = 9;
  localparam int OE_BIT   = 12;
  localparam int ON_BIT   = 15;
  localparam int DIV_LSB  = 16;
  localparam int TRIM_MSB = 31;

  typedef struct packed {
    logic run;   // divider may count
    logic load;  // copy staged div/trim into running set
  } dpStrobe_t;

endpackage

// File: rtl/frac_ref_div_ctrl.sv
module frac_ref_div_ctrl
  import frac_ref_div_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int DIV_W  = 15,
  parameter int TRIM_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       ctrlRd,
  output logic [31:0]       trimRd,
  output logic [SEL_W-1:0]  srcSel,
  output logic              oeOut,
  output logic [DIV_W-1:0]  stagedDiv,
  output logic [TRIM_W-1:0] stagedTrim,
  output dpStrobe_t         strobe
);

  localparam int TRIM_LSB = TRIM_MSB - TRIM_W + 1;

  logic [SEL_W-1:0]  selQ;
  logic              onQ, oeQ, activeQ, swPendQ;
  logic [DIV_W-1:0]  stDivQ;
  logic [TRIM_W-1:0] stTrimQ;
  logic              ctrlWr, trimWr;
  logic              unusedWdata;

  assign ctrlWr      = regWr && !regAddr;
  assign trimWr      = regWr && regAddr;
  assign unusedWdata = ^regWdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ    <= '0;
      onQ     <= 1'b0;
      oeQ     <= 1'b0;
      activeQ <= 1'b0;
      swPendQ <= 1'b0;
      stDivQ  <= '0;
      stTrimQ <= '0;
    end else begin
      activeQ <= onQ;
      swPendQ <= ctrlWr && regWdata[SW_BIT];
      if (ctrlWr) begin
        if (!activeQ) selQ <= regWdata[SEL_LSB +: SEL_W];
        oeQ    <= regWdata[OE_BIT];
        onQ    <= regWdata[ON_BIT];
        stDivQ <= regWdata[DIV_LSB +: DIV_W];
      end
      if (trimWr) stTrimQ <= regWdata[TRIM_LSB +: TRIM_W];
    end
  end

  always_comb begin
    ctrlRd                         = '0;
    ctrlRd[SEL_LSB +: SEL_W]       = selQ;
    ctrlRd[ACT_BIT]                = activeQ;
    ctrlRd[SW_BIT]                 = swPendQ;
    ctrlRd[OE_BIT]                 = oeQ;
    ctrlRd[ON_BIT]                 = onQ;
    ctrlRd[DIV_LSB +: DIV_W]       = stDivQ;
    trimRd                         = '0;
    trimRd[TRIM_LSB +: TRIM_W]     = stTrimQ;
  end

  assign srcSel      = selQ;
  assign oeOut       = oeQ;
  assign stagedDiv   = stDivQ;
  assign stagedTrim  = stTrimQ;
  assign strobe.run  = activeQ;
  assign strobe.load = swPendQ;

endmodule

// File: rtl/frac_ref_div_dp.sv
module frac_ref_div_dp
  import frac_ref_div_pkg::*;
#(
  parameter int DIV_W  = 15,
  parameter int TRIM_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DIV_W-1:0]  stagedDiv,
  input  logic [TRIM_W-1:0] stagedTrim,
  input  logic              oe,
  output logic              refOut
);

  localparam int LEN_W = DIV_W + 1;
  localparam int SUM_W = TRIM_W + 1;

  logic [DIV_W-1:0]  runDiv;
  logic [TRIM_W-1:0] runTrim;
  logic [TRIM_W-1:0] acc;
  logic [LEN_W-1:0]  cnt, curLen;
  logic              phase;
  logic [SUM_W-1:0]  accSum;
  logic              divZero, lastCyc;

  assign accSum  = {1'b0, acc} + {1'b0, runTrim};
  assign divZero = (runDiv == '0);
  assign lastCyc = (cnt == curLen - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runDiv  <= '0;
      runTrim <= '0;
      acc     <= '0;
      cnt     <= '0;
      curLen  <= '0;
      phase   <= 1'b0;
    end else if (strobe.load) begin
      runDiv  <= stagedDiv;
      runTrim <= stagedTrim;
      acc     <= '0;
      cnt     <= '0;
      curLen  <= {1'b0, stagedDiv};
    end else if (!strobe.run || divZero) begin
      acc    <= '0;
      cnt    <= '0;
      phase  <= 1'b0;
      curLen <= {1'b0, runDiv};
    end else if (lastCyc) begin
      cnt    <= '0;
      phase  <= ~phase;
      acc    <= accSum[TRIM_W-1:0];
      curLen <= {1'b0, runDiv} + LEN_W'(accSum[TRIM_W]);
    end else begin
      cnt <= cnt + LEN_W'(1);
    end
  end

  assign refOut = oe && strobe.run && (divZero ? clk : phase);

endmodule

// File: rtl/frac_ref_div.sv
module frac_ref_div
  import frac_ref_div_pkg::*;
#(
  parameter int SEL_W  = 4,
  parameter int DIV_W  = 15,
  parameter int TRIM_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      ctrlRd,
  output logic [31:0]      trimRd,
  output logic [SEL_W-1:0] srcSel,
  output logic             refOut
);

  dpStrobe_t         strobe;
  logic [DIV_W-1:0]  stagedDiv;
  logic [TRIM_W-1:0] stagedTrim;
  logic              oeBit;

  frac_ref_div_ctrl #(.SEL_W(SEL_W), .DIV_W(DIV_W), .TRIM_W(TRIM_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .ctrlRd(ctrlRd), .trimRd(trimRd), .srcSel(srcSel),
    .oeOut(oeBit), .stagedDiv(stagedDiv), .stagedTrim(stagedTrim),
    .strobe(strobe)
  );

  frac_ref_div_dp #(.DIV_W(DIV_W), .TRIM_W(TRIM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stagedDiv(stagedDiv),
    .stagedTrim(stagedTrim), .oe(oeBit), .refOut(refOut)
  );

endmodule

// File: rtl/frac_ref_div_chk.sv
module frac_ref_div_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWr,
  input logic        regAddr,
  input logic [31:0] ctrlRd,
  input logic [3:0]  srcSel,
  input logic        refOut
);

  p_sw_selfclear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd[9] && !(regWr && !regAddr)) |=> !ctrlRd[9]);

  p_active_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRd[15] |=> ctrlRd[8]);

  p_active_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRd[15] |=> !ctrlRd[8]);

  p_sel_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRd[8] && regWr && !regAddr) |=> $stable(srcSel));

  p_oe_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlRd[12] |-> !refOut);

  p_off_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlRd[15] && !ctrlRd[8]) |-> !refOut);

endmodule

bind frac_ref_div frac_ref_div_chk u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
  .ctrlRd(ctrlRd), .srcSel(srcSel), .refOut(refOut)
);

// File: tb/sim_frac_ref_div.sv
module sim_frac_ref_div;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regAddr = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] ctrlRd, trimRd;
  logic [3:0]  srcSel;
  logic        refOut;

  int passCnt = 0;
  int failCnt = 0;
  int totalCnt = 0;
  bit doneFlag = 1'b0;

  always #5 clk = ~clk;

  frac_ref_div u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .ctrlRd(ctrlRd), .trimRd(trimRd),
    .srcSel(srcSel), .refOut(refOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    totalCnt++;
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ctrlWord(input int sel, input int dv,
      input bit oe, input bit on, input bit sw);
    logic [31:0] w;
    w = '0;
    w[3:0] = sel[3:0];
    w[30:16] = dv[14:0];
    w[12] = oe;
    w[15] = on;
    w[9] = sw;
    return w;
  endfunction

  function automatic logic [31:0] trimWord(input int t);
    return {t[8:0], 23'd0};
  endfunction

  task automatic wrReg(input bit addr, input logic [31:0] data);
    @(negedge clk);
    regWr = 1'b1; regAddr = addr; regWdata = data;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  // Measure n half-periods after the next rising edge of refOut.
  task automatic measure(input int d, input int t, input int n, input string req);
    bit prev, inRange, found;
    int cyc, halves, total;
    found = 1'b0;
    @(negedge clk);
    prev = refOut;
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk);
      if (!prev && refOut) begin found = 1'b1; break; end
      prev = refOut;
    end
    check(found, req, "rising edge seen", found, 1);
    if (!found) return;
    prev = 1'b1; cyc = 0; halves = 0; total = 0; inRange = 1'b1;
    for (int g = 0; g < 20000 && halves < n; g++) begin
      @(negedge clk);
      cyc++;
      if (refOut != prev) begin
        if (t == 0) begin if (cyc != d) inRange = 1'b0; end
        else if (cyc != d && cyc != d + 1) inRange = 1'b0;
        total += cyc; cyc = 0; halves++; prev = refOut;
      end
    end
    check(inRange && halves == n, req, "half-period length in range", halves, n);
    if (n == 512)
      check(total == 512 * d + t, req, "cycles over 512 halves", total, 512 * d + t);
  endtask

  initial begin
    int seedDummy, d, t;
    int sel;
    bit ok;
    seedDummy = $urandom(32'd1234);
    sel = 10;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ctrlRd == 32'd0, "R1", "ctrlRd after reset", ctrlRd, 0);
    check(trimRd == 32'd0, "R1", "trimRd after reset", trimRd, 0);
    check(refOut == 1'b0, "R1", "refOut after reset", refOut, 0);

    // R2 field layout and read-zero bits
    wrReg(1'b1, 32'hFFFF_FFFF);
    check(trimRd == 32'hFF80_0000, "R2", "trim word layout", trimRd, 32'hFF80_0000);
    wrReg(1'b0, 32'h8003_01FA);
    check(ctrlRd == 32'h0003_000A, "R2", "control word layout", ctrlRd, 32'h0003_000A);
    check(srcSel == 4'hA, "R2", "srcSel port", srcSel, 4'hA);

    // R6/R7 switch self-clear and active timing, R4 integer divide
    wrReg(1'b1, trimWord(0));
    wrReg(1'b0, ctrlWord(sel, 4, 1, 1, 1));
    check(ctrlRd[9] == 1'b1, "R6", "switch bit set after write", ctrlRd[9], 1);
    check(ctrlRd[8] == 1'b0, "R7", "active not yet set", ctrlRd[8], 0);
    @(negedge clk);
    check(ctrlRd[9] == 1'b0, "R6", "switch bit self-cleared", ctrlRd[9], 0);
    check(ctrlRd[8] == 1'b1, "R7", "active set one cycle after on", ctrlRd[8], 1);
    measure(4, 0, 512, "R4");

    // R6 staged values have no effect until switch
    wrReg(1'b1, trimWord(200));
    wrReg(1'b0, ctrlWord(sel, 2, 1, 1, 0));
    measure(4, 0, 40, "R6");
    wrReg(1'b0, ctrlWord(sel, 2, 1, 1, 1));
    measure(2, 200, 512, "R6");

    // R3 boundary and random fractional settings
    wrReg(1'b1, trimWord(511));
    wrReg(1'b0, ctrlWord(sel, 1, 1, 1, 1));
    measure(1, 511, 512, "R3");
    for (int k = 0; k < 8; k++) begin
      d = 1 + int'($urandom % 7);
      t = int'($urandom % 512);
      wrReg(1'b1, trimWord(t));
      wrReg(1'b0, ctrlWord(sel, d, 1, 1, 1));
      measure(d, t, 512, "R3");
    end

    // R8 select frozen while active
    wrReg(1'b0, ctrlWord(5, d, 1, 1, 0));
    check(srcSel == 4'(sel), "R8", "srcSel held while active", srcSel, sel);

    // R9 output enable clear: low output, divider still running
    wrReg(1'b0, ctrlWord(sel, d, 0, 1, 0));
    ok = 1'b1;
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      if (refOut) ok = 1'b0;
    end
    check(ok, "R9", "refOut low with output disabled", refOut, 0);
    check(ctrlRd[8] == 1'b1, "R9", "active kept with output disabled", ctrlRd[8], 1);
    wrReg(1'b0, ctrlWord(sel, d, 1, 1, 0));
    measure(d, t, 512, "R9");

    // R10 off, then R8 select accepted when inactive
    wrReg(1'b0, ctrlWord(sel, d, 1, 0, 0));
    @(negedge clk);
    check(ctrlRd[8] == 1'b0, "R7", "active cleared after off", ctrlRd[8], 0);
    ok = 1'b1;
    for (int g = 0; g < 50; g++) begin
      @(negedge clk);
      if (refOut) ok = 1'b0;
    end
    check(ok, "R10", "refOut low while off", refOut, 0);
    wrReg(1'b0, ctrlWord(5, d, 1, 0, 0));
    check(srcSel == 4'h5, "R8", "srcSel written while inactive", srcSel, 5);

    // R5 pass-through with zero divider
    wrReg(1'b0, ctrlWord(5, 0, 1, 1, 1));
    repeat (3) @(negedge clk);
    ok = 1'b1;
    for (int g = 0; g < 4; g++) begin
      @(posedge clk); #1;
      if (refOut !== 1'b1) ok = 1'b0;
      @(negedge clk); #1;
      if (refOut !== 1'b0) ok = 1'b0;
    end
    check(ok, "R5", "refOut follows clk at zero divider", refOut, 0);

    doneFlag = 1'b1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!doneFlag) begin
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end

endmodule